// File: doc/BRIEF.md
# Audio Baud-Rate Clock Generator

This block derives two divided audio timing strobes, one intended for the 44.1 kHz sample-rate family and one for the 48 kHz family. It works in a single system-clock domain. Each of the four audio reference clocks (A, B, C and an internal clock I) is presented as a one-cycle enable strobe. Each of the two baud-rate dividers picks one reference through its own select field. It counts that reference's strobes through a power-of-four prescaler chained with an 8-bit counter, and emits a one-cycle tick at every terminal count.

A single external clock-out strobe is taken from either divider. A bank of per-channel selectors routes a raw reference strobe or a divided tick to each serial audio channel. The last channel has no selector of its own and follows the channel before it. Configuration goes through a simple write port. Address 0 is the clock-select register, addresses 1 and 2 are the divider registers for A and B, and addresses 3 and up hold the packed channel-select registers.

Top module: `audclk_gen`

## Requirements
- R1: After reset, both divider registers hold 2 (division by 6), both dividers take reference A, the clock-out follows divider A, every channel is stopped, and all outputs are low.
- R2: A divider register holds prescaler code p in bits 9:8 and n in bits 7:0. The divider ticks once per (2 << 2p) × (n + 1) strobes of its source. The tick is high for one cycle, the cycle after the strobe that completes the count.
- R3: Divider A's source is in clock-select bits 22:20 and divider B's source is in bits 18:16. Code 0 selects reference A, 1 selects B, 4 selects C and 2 selects I. Any other code gives no ticks.
- R4: Clock-select bit 31 routes divider B's tick to the clock-out when 1, and divider A's tick when 0.
- R5: A clock-select write takes effect only through bit 31, bits 22:20 and bits 18:16. All other written bits have no effect on any output.
- R6: A divider register written while its divider runs does not affect the period in progress. The new value applies from the next terminal count on.
- R7: A change of a divider's source select restarts its prescaler and counter from zero, with the current register value.
- R8: Each channel k has an 8-bit select field in channel-select register k/4 (address 3 + k/4), at bits (k mod 4)×8. Code 0x01 routes reference A, 0x02 B, 0x03 C, 0x10 divider A and 0x20 divider B. Any other nonzero code gives a silent channel.
- R9: A channel select field of 0 stops that channel: its output stays low.
- R10: The last channel has no select field. Its output always equals that of the channel before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_stb | input | 4 | Reference strobes: bit 0 = A, 1 = B, 2 = C, 3 = I |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| tick_a | output | 1 | Divider A tick |
| tick_b | output | 1 | Divider B tick |
| clkout_tick | output | 1 | External clock-out strobe |
| ch_tick | output | 9 | Per-channel clock strobes |

## Verification
The bench times the first tick after reset to the exact strobe. A design with an off-by-one in the prescaler or counter would tick one strobe early or late, or tick once per strobe on the wrong source code. It rewrites a divider register mid-period and expects the old period to finish first. It also swaps a source select mid-count and expects a full fresh period; a design that keeps stale counts would tick early. Junk in unmapped clock-select bits, a stopped channel, and a junk channel code must all leave outputs unchanged. Random rounds compare tick and channel counts against counts derived from delivered strobes.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

   // clock-select register layout (bit positions decoded by the dividers)
   localparam int CKR_OUT_BIT  = 31;
   localparam int CKR_SRCA_LSB = 20;
   localparam int CKR_SRCB_LSB = 16;
   localparam int SRC_W        = 3;
   localparam int FLD_W        = 8;

   // reference strobe positions on ref_stb
   typedef enum logic [1:0] {REF_A = 2'd0, REF_B = 2'd1, REF_C = 2'd2, REF_I = 2'd3} ref_idx_e;

   // channel select codes
   localparam logic [FLD_W-1:0] CH_ZERO = 8'h00;
   localparam logic [FLD_W-1:0] CH_REFA = 8'h01;
   localparam logic [FLD_W-1:0] CH_REFB = 8'h02;
   localparam logic [FLD_W-1:0] CH_REFC = 8'h03;
   localparam logic [FLD_W-1:0] CH_DIVA = 8'h10;
   localparam logic [FLD_W-1:0] CH_DIVB = 8'h20;

   // divider source decode: non-linear code to strobe
   function automatic logic brg_stb(input logic [SRC_W-1:0] code, input logic [3:0] stb);
      case (code)
         3'd0:    return stb[REF_A];
         3'd1:    return stb[REF_B];
         3'd4:    return stb[REF_C];
         3'd2:    return stb[REF_I];
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/audclk_brg.sv
module audclk_brg #(
   parameter int DIV_W   = 10,
   parameter int CNT_W   = 8,
   parameter int RST_VAL = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_stb,
   input  logic             restart,
   input  logic [DIV_W-1:0] div_cfg,
   output logic             tick
);
   localparam int PRE_W = DIV_W - CNT_W;
   localparam int PC_W  = 2 * (2**PRE_W - 1) + 1;

   if (PRE_W < 1) begin : g_bad_w
      $error("audclk_brg: DIV_W must exceed CNT_W");
   end

   function automatic logic [PC_W-1:0] pre_last(input logic [PRE_W-1:0] p);
      logic [PC_W:0] f;
      f = (PC_W+1)'(2) << (2 * p);
      return PC_W'(f - 1'b1);
   endfunction

   logic [DIV_W-1:0] act;
   logic [PC_W-1:0]  pcnt;
   logic [CNT_W-1:0] cnt;
   logic             pre_end, cnt_end;

   assign pre_end = (pcnt == pre_last(act[DIV_W-1:CNT_W]));
   assign cnt_end = (cnt == act[CNT_W-1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act  <= DIV_W'(RST_VAL);
         pcnt <= '0;
         cnt  <= '0;
         tick <= 1'b0;
      end else if (restart) begin
         act  <= div_cfg;
         pcnt <= '0;
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (src_stb) begin
            if (pre_end) begin
               pcnt <= '0;
               if (cnt_end) begin
                  cnt  <= '0;
                  tick <= 1'b1;
                  act  <= div_cfg;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end else begin
               pcnt <= pcnt + 1'b1;
            end
         end
      end
   end

   // R2: total division is at least 2, so ticks never come back to back
   assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R2: a tick always follows an accepted source strobe
   assert_tick_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> ($past(src_stb) && !$past(restart)));

   // R2: the counter never passes its terminal value
   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= act[CNT_W-1:0]);

   // R7: a restart cycle is never followed by a tick
   assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !tick);

   // R6: the active setting only moves at terminal count or restart
   assert_hold_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !(src_stb && pre_end && cnt_end)) |=> $stable(act));

endmodule

// File: rtl/audclk_chsel.sv
module audclk_chsel #(
   parameter bit ZERO_STOPS = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] code,
   input  logic [3:0] ref_stb,
   input  logic       tick_a,
   input  logic       tick_b,
   output logic       ch_tick
);
   import audclk_pkg::*;

   logic zero_src;

   if (ZERO_STOPS) begin : g_zero_stop
      assign zero_src = 1'b0;
   end else begin : g_zero_refi
      assign zero_src = ref_stb[REF_I];
   end

   always_comb begin
      case (code)
         CH_ZERO: ch_tick = zero_src;
         CH_REFA: ch_tick = ref_stb[REF_A];
         CH_REFB: ch_tick = ref_stb[REF_B];
         CH_REFC: ch_tick = ref_stb[REF_C];
         CH_DIVA: ch_tick = tick_a;
         CH_DIVB: ch_tick = tick_b;
         default: ch_tick = 1'b0;
      endcase
   end

   if (ZERO_STOPS) begin : g_chk_stop
      // R9: a zero field keeps the channel silent
      assert_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (code == CH_ZERO) |-> !ch_tick);
   end

endmodule

// File: rtl/audclk_gen.sv
module audclk_gen #(
   parameter int NUM_CH     = 9,
   parameter bit SHARE_LAST = 1'b1,
   parameter bit ZERO_STOPS = 1'b1,
   parameter int ADDR_W     = 3,
   parameter int DIV_W      = 10,
   parameter int CNT_W      = 8,
   parameter int DIV_RST    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        ref_stb,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   output logic              tick_a,
   output logic              tick_b,
   output logic              clkout_tick,
   output logic [NUM_CH-1:0] ch_tick
);
   import audclk_pkg::*;

   localparam int NUM_FLD    = SHARE_LAST ? NUM_CH - 1 : NUM_CH;
   localparam int FLD_PER_RG = 32 / FLD_W;
   localparam int NUM_SELREG = (NUM_FLD + FLD_PER_RG - 1) / FLD_PER_RG;
   localparam int ADR_CKR    = 0;
   localparam int ADR_DIVA   = 1;
   localparam int ADR_DIVB   = 2;
   localparam int ADR_CH0    = 3;

   if (NUM_CH < 2) begin : g_bad_ch
      $error("audclk_gen: NUM_CH must be at least 2");
   end
   if (ADR_CH0 + NUM_SELREG > 2**ADDR_W) begin : g_bad_addr
      $error("audclk_gen: ADDR_W too small for channel registers");
   end

   logic                 out_sel;
   logic [SRC_W-1:0]     sel_a, sel_b, sel_a_q, sel_b_q;
   logic [DIV_W-1:0]     div_a, div_b;
   logic [31:0]          chreg [NUM_SELREG];
   logic                 wr_ckr;

   assign wr_ckr = wr_en && (int'(wr_addr) == ADR_CKR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_sel <= 1'b0;
         sel_a   <= '0;
         sel_b   <= '0;
         sel_a_q <= '0;
         sel_b_q <= '0;
         div_a   <= DIV_W'(DIV_RST);
         div_b   <= DIV_W'(DIV_RST);
      end else begin
         sel_a_q <= sel_a;
         sel_b_q <= sel_b;
         if (wr_ckr) begin
            out_sel <= wr_data[CKR_OUT_BIT];
            sel_a   <= wr_data[CKR_SRCA_LSB +: SRC_W];
            sel_b   <= wr_data[CKR_SRCB_LSB +: SRC_W];
         end
         if (wr_en && int'(wr_addr) == ADR_DIVA) div_a <= wr_data[DIV_W-1:0];
         if (wr_en && int'(wr_addr) == ADR_DIVB) div_b <= wr_data[DIV_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      for (int r = 0; r < NUM_SELREG; r++) begin
         if (!rst_n)
            chreg[r] <= '0;
         else if (wr_en && int'(wr_addr) == ADR_CH0 + r)
            chreg[r] <= wr_data;
      end
   end

   audclk_brg #(.DIV_W(DIV_W), .CNT_W(CNT_W), .RST_VAL(DIV_RST)) u_brg_a (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_stb (brg_stb(sel_a, ref_stb)),
      .restart (sel_a != sel_a_q),
      .div_cfg (div_a),
      .tick    (tick_a)
   );

   audclk_brg #(.DIV_W(DIV_W), .CNT_W(CNT_W), .RST_VAL(DIV_RST)) u_brg_b (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_stb (brg_stb(sel_b, ref_stb)),
      .restart (sel_b != sel_b_q),
      .div_cfg (div_b),
      .tick    (tick_b)
   );

   assign clkout_tick = out_sel ? tick_b : tick_a;

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      localparam int FLD = (SHARE_LAST && k == NUM_CH - 1) ? k - 1 : k;
      audclk_chsel #(.ZERO_STOPS(ZERO_STOPS)) u_sel (
         .clk     (clk),
         .rst_n   (rst_n),
         .code    (chreg[FLD / FLD_PER_RG][(FLD % FLD_PER_RG) * FLD_W +: FLD_W]),
         .ref_stb (ref_stb),
         .tick_a  (tick_a),
         .tick_b  (tick_b),
         .ch_tick (ch_tick[k])
      );
   end

   if (SHARE_LAST) begin : g_chk_share
      // R10: the last channel mirrors its neighbour
      assert_share_R10: assert property (@(posedge clk) disable iff (!rst_n)
         ch_tick[NUM_CH-1] == ch_tick[NUM_CH-2]);
   end

   // R4: the clock-out never pulses unless the selected divider does
   assert_clkout_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clkout_tick |-> (tick_a || tick_b));

endmodule

// File: tb/sim_audclk_gen.sv
module sim_audclk_gen;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 9;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [3:0]     ref_stb = '0;
   logic           wr_en = 1'b0;
   logic [2:0]     wr_addr = '0;
   logic [31:0]    wr_data = '0;
   logic           tick_a, tick_b, clkout_tick;
   logic [NCH-1:0] ch_tick;

   int checks = 0, errors = 0;
   int n_ta, n_tb, n_co, first_ta;
   int n_ch [NCH];
   int s_cnt [4];
   bit done = 1'b0;

   audclk_gen u0 (
      .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .tick_a(tick_a), .tick_b(tick_b),
      .clkout_tick(clkout_tick), .ch_tick(ch_tick)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // sample at the falling edge, then drive the next stimulus
   task automatic step(input logic [3:0] s);
      @(negedge clk);
      n_ta += int'(tick_a);
      n_tb += int'(tick_b);
      n_co += int'(clkout_tick);
      for (int k = 0; k < NCH; k++) n_ch[k] += int'(ch_tick[k]);
      if (tick_a && first_ta < 0) first_ta = s_cnt[0];
      ref_stb = s;
      for (int b = 0; b < 4; b++) s_cnt[b] += int'(s[b]);
   endtask

   task automatic clr();
      n_ta = 0; n_tb = 0; n_co = 0; first_ta = -1;
      for (int k = 0; k < NCH; k++) n_ch[k] = 0;
      for (int b = 0; b < 4; b++) s_cnt[b] = 0;
   endtask

   task automatic run(input logic [3:0] s, input int cnt);
      for (int i = 0; i < cnt; i++) step(s);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step(4'b0000);
      wr_en = 1'b0;
      step(4'b0000);
      step(4'b0000);
   endtask

   function automatic int divof(input int p, input int n);
      return (2 << (2 * p)) * (n + 1);
   endfunction

   function automatic int srcbit(input int code);
      case (code)
         0: return 0;
         1: return 1;
         4: return 2;
         2: return 3;
         default: return -1;
      endcase
   endfunction

   function automatic int chexp(input int code, input int ta, input int tb);
      case (code)
         8'h01: return s_cnt[0];
         8'h02: return s_cnt[1];
         8'h03: return s_cnt[2];
         8'h10: return ta;
         8'h20: return tb;
         default: return 0;
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int codes [4] = '{0, 1, 4, 2};
      int pool [7] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h10, 8'h20, 8'h07};
      int chc [NCH];
      void'($urandom(32'd20240611));
      clr();
      repeat (3) @(negedge clk);
      // R1: reset state of outputs
      chk("R1 tick_a at reset", int'(tick_a), 0);
      chk("R1 clkout at reset", int'(clkout_tick), 0);
      chk("R1 ch_tick at reset", int'(ch_tick), 0);
      rst_n = 1'b1;

      // R1 / R2: default divide by 6 from reference A, first tick timing
      clr();
      run(4'b0001, 12); step(4'b0000);
      chk("R1 default tick_a count", n_ta, 2);
      chk("R1 default tick_b count", n_tb, 2);
      chk("R2 first tick after strobe", first_ta, 6);
      chk("R9 channel 0 stopped after reset", n_ch[0], 0);
      clr(); run(4'b1110, 20); step(4'b0000);
      chk("R3 other refs ignored by default", n_ta, 0);

      // R3: source encoding of divider A, B parked on invalid code 7
      foreach (codes[i]) begin
         wr(3'd0, (32'(codes[i]) << 20) | (32'd7 << 16));
         clr(); run(4'(1 << srcbit(codes[i])), 12); step(4'b0000);
         chk($sformatf("R3 divA code %0d own source", codes[i]), n_ta, 2);
         chk("R3 divB invalid code silent", n_tb, 0);
         clr(); run(4'b1111 & ~4'(1 << srcbit(codes[i])), 12); step(4'b0000);
         chk($sformatf("R3 divA code %0d other sources", codes[i]), n_ta, 0);
      end
      wr(3'd0, (32'd3 << 20) | (32'd4 << 16));
      clr(); run(4'b1111, 12); step(4'b0000);
      chk("R3 divA code 3 silent", n_ta, 0);
      chk("R3 divB code 4 takes ref C", n_tb, 2);

      // R5: junk in unmapped bits has no effect
      wr(3'd0, 32'h7F88FFFF);
      clr(); run(4'b0001, 12); step(4'b0000);
      chk("R5 tick_a with junk bits", n_ta, 2);
      chk("R5 tick_b with junk bits", n_tb, 2);
      chk("R5 clkout with junk bits", n_co, 2);

      // R4: clock-out selection (divA /6 on A, divB /8 on B)
      wr(3'd2, 32'h100);
      wr(3'd0, 32'h0001_0000);
      clr(); run(4'b0011, 48); step(4'b0000);
      chk("R2 divB prescale 8", n_tb, 6);
      chk("R4 clkout from divA", n_co, 8);
      wr(3'd0, 32'h8001_0000);
      clr(); run(4'b0011, 48); step(4'b0000);
      chk("R4 clkout from divB", n_co, 6);
      chk("R4 divA unaffected", n_ta, 8);

      // R6: new divider value waits for terminal count
      run(4'b0001, 3);
      wr(3'd1, 32'h004);
      clr(); run(4'b0001, 2); step(4'b0000);
      chk("R6 old period not yet done", n_ta, 0);
      run(4'b0001, 1); step(4'b0000);
      chk("R6 old period completes", n_ta, 1);
      run(4'b0001, 9); step(4'b0000);
      chk("R6 new period not yet done", n_ta, 1);
      run(4'b0001, 1); step(4'b0000);
      chk("R6 new period of 10", n_ta, 2);

      // R7: source change restarts the count
      run(4'b0001, 4);
      wr(3'd0, 32'h8011_0000);
      clr(); run(4'b0010, 9); step(4'b0000);
      chk("R7 no early tick after restart", n_ta, 0);
      run(4'b0010, 1); step(4'b0000);
      chk("R7 full period after restart", n_ta, 1);

      // R8 / R9 / R10: directed channel routing
      wr(3'd3, 32'h1003_0201);
      wr(3'd4, 32'h2010_0700);
      clr();
      for (int i = 0; i < 300; i++) step(4'($urandom_range(0, 15)));
      step(4'b0000);
      chk("R8 ch0 ref A", n_ch[0], s_cnt[0]);
      chk("R8 ch1 ref B", n_ch[1], s_cnt[1]);
      chk("R8 ch2 ref C", n_ch[2], s_cnt[2]);
      chk("R8 ch3 divA", n_ch[3], n_ta);
      chk("R9 ch4 stopped", n_ch[4], 0);
      chk("R8 ch5 junk code silent", n_ch[5], 0);
      chk("R8 ch6 divA", n_ch[6], n_ta);
      chk("R8 ch7 divB", n_ch[7], n_tb);
      chk("R10 ch8 follows ch7", n_ch[8], n_ch[7]);

      // random rounds: R2 division and R8 routing
      for (int rnd = 0; rnd < 6; rnd++) begin
         int pa, na, pb, nb, ca, cb, osel;
         pa = $urandom_range(0, 2); na = $urandom_range(0, 7);
         pb = $urandom_range(0, 2); nb = $urandom_range(0, 7);
         ca = codes[$urandom_range(0, 3)]; cb = codes[$urandom_range(0, 3)];
         osel = $urandom_range(0, 1);
         for (int k = 0; k < NCH - 1; k++) chc[k] = pool[$urandom_range(0, 6)];
         chc[NCH-1] = chc[NCH-2];
         wr(3'd1, 32'((pa << 8) | na));
         wr(3'd2, 32'((pb << 8) | nb));
         wr(3'd3, 32'((chc[3] << 24) | (chc[2] << 16) | (chc[1] << 8) | chc[0]));
         wr(3'd4, 32'((chc[7] << 24) | (chc[6] << 16) | (chc[5] << 8) | chc[4]));
         wr(3'd0, (32'd7 << 20) | (32'd7 << 16));
         wr(3'd0, (32'(osel) << 31) | (32'(ca) << 20) | (32'(cb) << 16));
         clr();
         for (int i = 0; i < 600; i++) step(4'($urandom_range(0, 15)));
         step(4'b0000);
         chk($sformatf("R2 random divA round %0d", rnd), n_ta, s_cnt[srcbit(ca)] / divof(pa, na));
         chk($sformatf("R2 random divB round %0d", rnd), n_tb, s_cnt[srcbit(cb)] / divof(pb, nb));
         chk($sformatf("R4 random clkout round %0d", rnd), n_co, osel ? n_tb : n_ta);
         for (int k = 0; k < NCH; k++)
            chk($sformatf("R8 random ch%0d round %0d", k, rnd), n_ch[k], chexp(chc[k], n_ta, n_tb));
      end

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule